// File: doc/BRIEF.md
# Dual-Buffer Transmit Controller

This block is the host side of the transmit path of a small Ethernet MAC. The host sees two frame buffers, ping and pong, through a word-addressed 32-bit register bus. Each buffer has a data area for frame words, a frame length register and a status register. The host fills a buffer, writes the length, and then sets the buffer's busy bit. This hands the buffer to a frame serializer. The serializer is modelled here as a fixed-latency handshake. When the serializer reports completion, the controller clears busy and, if the buffer's interrupt enable is set, pulses an interrupt.

The same busy handshake also serves as a command. If the program bit is set together with busy, the controller loads the first six bytes of that buffer into the station address register and transmits nothing. A write that clears busy cancels the pending or running operation of that buffer. The serializer serves one buffer at a time, in the order in which the buffers became busy. A parameter removes the pong buffer.

Top module: `dbtx_ctrl`

## Requirements
- R1: Frame data word i (0 <= i < DATA_WORDS) of a buffer is at word index i within the buffer and reads back what was last written there. The other words of the data area read zero and ignore writes. Word indices 0x1FE and 0x1FC also read zero.
- R2: The pong buffer uses the same layout as ping, offset by 0x200 words (bus_waddr bit 9 = 1). Its storage is independent of ping.
- R3: The length register is at word index 0x1FD. It stores bits 15:0 of the written data and reads back with bits 31:16 zero.
- R4: The status register is at word index 0x1FF. Bit 3 (interrupt enable) and bit 31 (software flag) are stored on every status write and read back. Neither bit starts anything.
- R5: A status write with bit 0 = 1 and bit 1 = 0 to an idle buffer sets busy (bit 0). If the serializer is free, tx_start is high in the following cycle, with tx_sel = buffer index and tx_len = that buffer's length. Busy first reads 0 SER_CYCLES+1 cycles after the write edge.
- R6: Only one buffer is served at a time. A buffer made busy while the other is being served waits and is served next. tx_start never pulses while tx_active is high.
- R7: irq is high for one cycle in the first cycle in which a completed buffer's busy reads 0, but only if that buffer's bit 3 is 1. It stays low otherwise.
- R8: A status write with bit 0 = 0 to a busy buffer clears bits 0 and 1, stops its transmission in the next cycle (tx_active low), and produces no irq.
- R9: A status write with bits 1:0 = 11 copies buffer bytes 0..5 to station_addr, without asserting tx_start. Byte 0 is word 0 bits 31:24 and maps to station_addr[47:40]; byte 5 is word 1 bits 23:16. Bits 1:0 read 0 one cycle after the write.
- R10: With PONG_EN = 0, every pong word reads zero, pong writes are ignored and tx_sel = 1 never starts.
- R11: After reset all registers, irq, tx_start, tx_active and station_addr are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_waddr | input | 10 | Word address; bit 9 selects pong |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_waddr, combinational |
| tx_start | output | 1 | One-cycle start of a frame to the serializer |
| tx_sel | output | 1 | Buffer being started or served |
| tx_len | output | 16 | Length of the selected buffer |
| tx_active | output | 1 | Serializer occupied |
| irq | output | 1 | Completion interrupt pulse |
| station_addr | output | 48 | Loaded station address |

## Verification
The hardest case to reach from the ports is a buffer that becomes busy while the other buffer is mid-transmission, and is then handed over cleanly when the first one completes. The stimulus starts ping and sets pong in the very next bus cycle, and then does the same in the opposite order. A cancel is issued in the middle of a running frame, and an address load on pong is checked for the exact cycle in which both of its command bits clear. Randomised rounds mix buffers, lengths, interrupt enables and data words. A second instance with the pong buffer removed watches the same bus.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;

    localparam int          WIDX_W    = 9;
    localparam logic [8:0]  LEN_WIDX  = 9'h1FD;
    localparam logic [8:0]  STAT_WIDX = 9'h1FF;

    localparam int ST_BUSY = 0;
    localparam int ST_PROG = 1;
    localparam int ST_IE   = 3;
    localparam int ST_SW   = 31;

    typedef struct packed {
        logic        busy;
        logic        prog;
        logic        ie;
        logic        sw;
        logic [15:0] len;
    } bufregs_t;

    typedef struct packed {
        logic        active;
        logic        cur;
        logic        order;
        logic        irq;
        logic [47:0] station;
    } sched_t;

endpackage

// File: rtl/dbtx_buf.sv
module dbtx_buf
    import dbtx_pkg::*;
#(
    parameter int DATA_WORDS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] widx,
    input  logic [31:0]       wdata,
    input  logic              hw_clr,
    output logic [31:0]       rdata,
    output logic              busy_o,
    output logic              prog_o,
    output logic              ie_o,
    output logic [15:0]       len_o,
    output logic [31:0]       w0_o,
    output logic [15:0]       w1hi_o,
    output logic              set_evt_o,
    output logic              cancel_evt_o
);

    localparam int IDX_W = (DATA_WORDS > 2) ? $clog2(DATA_WORDS) : 1;

    bufregs_t    r_d, r_q;
    logic [31:0] mem_q [DATA_WORDS];
    logic        in_data, stat_wr, len_wr;

    assign in_data = (widx < WIDX_W'(DATA_WORDS));
    assign stat_wr = wr_en && (widx == STAT_WIDX);
    assign len_wr  = wr_en && (widx == LEN_WIDX);

    assign set_evt_o    = stat_wr &&  wdata[ST_BUSY] && !r_q.busy;
    assign cancel_evt_o = stat_wr && !wdata[ST_BUSY] &&  r_q.busy;

    always_comb begin
        r_d = r_q;
        if (stat_wr) begin
            r_d.ie = wdata[ST_IE];
            r_d.sw = wdata[ST_SW];
            if (wdata[ST_BUSY]) begin
                r_d.busy = 1'b1;
                if (!r_q.busy) r_d.prog = wdata[ST_PROG];
            end else begin
                r_d.busy = 1'b0;
                r_d.prog = 1'b0;
            end
        end
        if (len_wr) r_d.len = wdata[15:0];
        if (hw_clr) begin
            r_d.busy = 1'b0;
            r_d.prog = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DATA_WORDS; i++) mem_q[i] <= '0;
        end else if (wr_en && in_data) begin
            mem_q[widx[IDX_W-1:0]] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (widx == STAT_WIDX)
            rdata = {r_q.sw, 27'b0, r_q.ie, 1'b0, r_q.prog, r_q.busy};
        else if (widx == LEN_WIDX)
            rdata = {16'b0, r_q.len};
        else if (in_data)
            rdata = mem_q[widx[IDX_W-1:0]];
    end

    assign busy_o = r_q.busy;
    assign prog_o = r_q.prog;
    assign ie_o   = r_q.ie;
    assign len_o  = r_q.len;
    assign w0_o   = mem_q[0];
    assign w1hi_o = mem_q[1][31:16];

endmodule

// File: rtl/dbtx_ser.sv
module dbtx_ser #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic done
);

    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (abort)
            cnt_d = '0;
        else if (start)
            cnt_d = CNT_W'(CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/dbtx_sched.sv
module dbtx_sched
    import dbtx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       busy,
    input  logic [1:0]       prog,
    input  logic [1:0]       ie,
    input  logic [1:0]       set_evt,
    input  logic [1:0]       cancel_evt,
    input  logic [1:0][31:0] w0,
    input  logic [1:0][15:0] w1hi,
    input  logic             ser_done,
    output logic             start,
    output logic             abort,
    output logic             sel,
    output logic [1:0]       clr,
    output logic             active,
    output logic             irq,
    output logic [47:0]      station
);

    sched_t     s_d, s_q;
    logic [1:0] pre_wait, waiting;
    logic       pick;

    always_comb begin
        for (int b = 0; b < 2; b++) begin
            pre_wait[b] = busy[b] && !(s_q.active && (s_q.cur == 1'(b)));
            waiting[b]  = pre_wait[b] && !cancel_evt[b];
        end
        pick = (&waiting) ? s_q.order : waiting[1];
    end

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        start   = 1'b0;
        abort   = 1'b0;
        clr     = '0;
        if (set_evt[0] && !pre_wait[1]) s_d.order = 1'b0;
        if (set_evt[1] && !pre_wait[0]) s_d.order = 1'b1;
        if (s_q.active) begin
            if (cancel_evt[s_q.cur]) begin
                abort      = 1'b1;
                s_d.active = 1'b0;
            end else if (ser_done) begin
                clr[s_q.cur] = 1'b1;
                s_d.irq      = ie[s_q.cur];
                s_d.active   = 1'b0;
            end
        end else if (|waiting) begin
            if (prog[pick]) begin
                clr[pick]   = 1'b1;
                s_d.irq     = ie[pick];
                s_d.station = {w0[pick], w1hi[pick]};
            end else begin
                start      = 1'b1;
                s_d.active = 1'b1;
                s_d.cur    = pick;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sel     = s_d.cur;
    assign active  = s_q.active;
    assign irq     = s_q.irq;
    assign station = s_q.station;

endmodule

// File: rtl/dbtx_ctrl.sv
module dbtx_ctrl
    import dbtx_pkg::*;
#(
    parameter int DATA_WORDS = 32,
    parameter int SER_CYCLES = 8,
    parameter bit PONG_EN    = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [9:0]  bus_waddr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tx_start,
    output logic        tx_sel,
    output logic [15:0] tx_len,
    output logic        tx_active,
    output logic        irq,
    output logic [47:0] station_addr
);

    localparam int NBUF = PONG_EN ? 2 : 1;

    logic [1:0][31:0] rd_a, w0_a;
    logic [1:0][15:0] len_a, w1hi_a;
    logic [1:0]       busy_a, prog_a, ie_a, set_a, cancel_a, clr_a;
    logic             ser_start, ser_abort, ser_done;

    for (genvar b = 0; b < 2; b++) begin : g_buf
        if (b < NBUF) begin : g_on
            dbtx_buf #(.DATA_WORDS(DATA_WORDS)) u_buf (
                .clk          (clk),
                .rst_n        (rst_n),
                .wr_en        (bus_we && (bus_waddr[9] == 1'(b))),
                .widx         (bus_waddr[8:0]),
                .wdata        (bus_wdata),
                .hw_clr       (clr_a[b]),
                .rdata        (rd_a[b]),
                .busy_o       (busy_a[b]),
                .prog_o       (prog_a[b]),
                .ie_o         (ie_a[b]),
                .len_o        (len_a[b]),
                .w0_o         (w0_a[b]),
                .w1hi_o       (w1hi_a[b]),
                .set_evt_o    (set_a[b]),
                .cancel_evt_o (cancel_a[b])
            );
        end else begin : g_off
            assign rd_a[b]     = '0;
            assign busy_a[b]   = 1'b0;
            assign prog_a[b]   = 1'b0;
            assign ie_a[b]     = 1'b0;
            assign len_a[b]    = '0;
            assign w0_a[b]     = '0;
            assign w1hi_a[b]   = '0;
            assign set_a[b]    = 1'b0;
            assign cancel_a[b] = 1'b0;
        end
    end

    dbtx_sched u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy_a),
        .prog       (prog_a),
        .ie         (ie_a),
        .set_evt    (set_a),
        .cancel_evt (cancel_a),
        .w0         (w0_a),
        .w1hi       (w1hi_a),
        .ser_done   (ser_done),
        .start      (ser_start),
        .abort      (ser_abort),
        .sel        (tx_sel),
        .clr        (clr_a),
        .active     (tx_active),
        .irq        (irq),
        .station    (station_addr)
    );

    dbtx_ser #(.CYCLES(SER_CYCLES)) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ser_start),
        .abort (ser_abort),
        .done  (ser_done)
    );

    assign bus_rdata = rd_a[bus_waddr[9]];
    assign tx_start  = ser_start;
    assign tx_len    = len_a[tx_sel];

endmodule

// File: rtl/dbtx_ctrl_chk.sv
module dbtx_ctrl_chk #(
    parameter bit PONG_EN = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we,
    input logic [9:0]  bus_waddr,
    input logic [31:0] bus_wdata,
    input logic        tx_start,
    input logic        tx_sel,
    input logic        tx_active,
    input logic [47:0] station_addr
);

    // R6: a start only leaves an idle serializer
    p_start_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !tx_active);

    // R6: starts never come back to back
    p_single_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    // R5: the served buffer holds while the serializer runs
    p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && $past(tx_active)) |-> $stable(tx_sel));

    // R8: cancelling the served buffer stops the serializer
    p_cancel_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_waddr[8:0] == 9'h1FF && !bus_wdata[0] && tx_active
         && bus_waddr[9] == tx_sel) |=> !tx_active);

    // R9: the station address only changes while idle
    p_station_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(station_addr) |-> !tx_active);

    // R10: without pong no pong start
    p_pong_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (PONG_EN || !tx_sel));

endmodule

bind dbtx_ctrl dbtx_ctrl_chk #(.PONG_EN(PONG_EN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_waddr    (bus_waddr),
    .bus_wdata    (bus_wdata),
    .tx_start     (tx_start),
    .tx_sel       (tx_sel),
    .tx_active    (tx_active),
    .station_addr (station_addr)
);

// File: tb/dbtx_ctrl_test.sv
`timescale 1ns/1ps
module dbtx_ctrl_test;

    localparam int NW  = 32;
    localparam int SER = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata, np_rdata;
    logic        tx_start, tx_sel, tx_active, irq;
    logic [15:0] tx_len;
    logic [47:0] station;
    logic        np_start, np_sel, np_active, np_irq;
    logic [15:0] np_len;
    logic [47:0] np_station;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [31:0] em [2][NW];

    always #4 clk = ~clk;

    dbtx_ctrl #(.DATA_WORDS(NW), .SER_CYCLES(SER), .PONG_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata), .tx_start(tx_start),
        .tx_sel(tx_sel), .tx_len(tx_len), .tx_active(tx_active), .irq(irq),
        .station_addr(station));

    dbtx_ctrl #(.DATA_WORDS(NW), .SER_CYCLES(SER), .PONG_EN(1'b0)) uut_np (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_rdata(np_rdata), .tx_start(np_start),
        .tx_sel(np_sel), .tx_len(np_len), .tx_active(np_active), .irq(np_irq),
        .station_addr(np_station));

    function automatic logic [9:0] wa(input bit b, input logic [8:0] i);
        return {b, i};
    endfunction

    function automatic logic [31:0] exp_stat(input bit sw, input bit ie);
        return {sw, 27'b0, ie, 3'b000};
    endfunction

    function automatic logic [47:0] exp_station(input logic [31:0] a, input logic [31:0] b);
        return {a, b[31:16]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d, output logic [31:0] dn);
        bus_waddr = a;
        #1;
        d = rdata; dn = np_rdata;
    endtask

    task automatic send(input bit b, input logic [15:0] len, input bit ie, input bit sw);
        logic [31:0] d, dn;
        int k;
        wr(wa(b, 9'h1FD), {$urandom, len}[31:0]);
        wr(wa(b, 9'h1FF), {sw, 27'b0, ie, 3'b001});
        chk(tx_start == 1'b1, "R5 start", tx_start, 1);
        chk(tx_sel == b && tx_len == len, "R5 sel/len", {tx_sel, tx_len}, {b, len});
        k = 0;
        forever begin
            rd(wa(b, 9'h1FF), d, dn);
            if (d[0] == 1'b0 || k > 4 * SER) break;
            @(negedge clk); k++;
        end
        chk(k == SER + 1, "R5 busy duration", k, SER + 1);
        chk(irq == ie, "R7 irq at completion", irq, ie);
        chk(d == exp_stat(sw, ie), "R4 status kept", d, exp_stat(sw, ie));
        @(negedge clk);
        chk(irq == 1'b0, "R7 irq one cycle", irq, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, dn;
        bit ok;
        void'($urandom(32'h5EED));
        for (int b = 0; b < 2; b++) for (int i = 0; i < NW; i++) em[b][i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        rd(wa(0, 9'h1FF), d, dn); chk(d == 0, "R11 ping status", d, 0);
        rd(wa(1, 9'h1FF), d, dn); chk(d == 0, "R11 pong status", d, 0);
        rd(wa(1, 9'h1FD), d, dn); chk(d == 0, "R11 pong length", d, 0);
        chk({irq, tx_start, tx_active} == 0 && station == 0, "R11 outputs",
            {irq, tx_start, tx_active, station}, 0);

        // R3 length field
        wr(wa(0, 9'h1FD), 32'hABCD_1234);
        rd(wa(0, 9'h1FD), d, dn); chk(d == 32'h0000_1234, "R3 length", d, 32'h1234);
        wr(wa(1, 9'h1FD), 32'h5555_00FE);
        rd(wa(1, 9'h1FD), d, dn); chk(d == 32'h0000_00FE, "R2 pong length", d, 32'hFE);
        rd(wa(0, 9'h1FD), d, dn); chk(d == 32'h0000_1234, "R2 ping unchanged", d, 32'h1234);

        // R4 flags stored, no start
        wr(wa(0, 9'h1FF), 32'h8000_0008);
        rd(wa(0, 9'h1FF), d, dn); chk(d == 32'h8000_0008, "R4 flags", d, 32'h8000_0008);
        chk(tx_start == 0 && tx_active == 0, "R4 no start", {tx_start, tx_active}, 0);
        @(negedge clk);
        chk(tx_active == 0, "R4 still idle", tx_active, 0);

        // R1 outside the data area
        wr(wa(0, 9'd40), 32'hDEAD_BEEF);
        rd(wa(0, 9'd40), d, dn); chk(d == 0, "R1 unmapped word", d, 0);
        rd(wa(0, 9'h1FE), d, dn); chk(d == 0, "R1 hole 0x1FE", d, 0);
        rd(wa(0, 9'h1FC), d, dn); chk(d == 0, "R1 hole 0x1FC", d, 0);

        // R5 R7 directed sends
        send(0, 16'd60, 1'b1, 1'b1);
        send(1, 16'd1514, 1'b0, 1'b0);

        // R6 ping then pong while ping runs
        wr(wa(0, 9'h1FD), 32'd100);
        wr(wa(1, 9'h1FD), 32'd200);
        wr(wa(0, 9'h1FF), 32'h1);
        chk(tx_start && tx_sel == 0, "R6 ping first", {tx_start, tx_sel}, 2'b10);
        wr(wa(1, 9'h1FF), 32'h1);
        chk(tx_start == 0 && tx_active == 1, "R6 pong waits", {tx_start, tx_active}, 2'b01);
        ok = 1'b0;
        for (int i = 0; i < 4 * SER; i++) begin
            if (tx_start) begin ok = (tx_sel == 1 && tx_len == 16'd200); break; end
            @(negedge clk);
        end
        chk(ok, "R6 pong served next", {tx_sel, tx_len}, {1'b1, 16'd200});
        rd(wa(0, 9'h1FF), d, dn); chk(d[0] == 0, "R6 ping done before pong", d, 0);
        repeat (2 * SER) @(negedge clk);

        // R6 reverse order
        wr(wa(1, 9'h1FF), 32'h1);
        chk(tx_start && tx_sel == 1, "R6 pong first", {tx_start, tx_sel}, 2'b11);
        wr(wa(0, 9'h1FF), 32'h1);
        ok = 1'b0;
        for (int i = 0; i < 4 * SER; i++) begin
            if (tx_start) begin ok = (tx_sel == 0 && tx_len == 16'd100); break; end
            @(negedge clk);
        end
        chk(ok, "R6 ping served next", {tx_sel, tx_len}, {1'b0, 16'd100});
        repeat (2 * SER) @(negedge clk);

        // R8 cancel mid frame
        wr(wa(0, 9'h1FF), 32'h9);
        repeat (3) @(negedge clk);
        wr(wa(0, 9'h1FF), 32'h8);
        chk(tx_active == 0, "R8 serializer stopped", tx_active, 0);
        rd(wa(0, 9'h1FF), d, dn); chk(d == 32'h8, "R8 status after cancel", d, 8);
        ok = 1'b1;
        for (int i = 0; i < SER + 4; i++) begin
            if (irq || tx_start) ok = 1'b0;
            @(negedge clk);
        end
        chk(ok, "R8 no irq after cancel", ok, 1);

        // R9 station address load from pong
        wr(wa(1, 9'd0), 32'h02AA_BBCC);
        wr(wa(1, 9'd1), 32'hDDEE_1122);
        em[1][0] = 32'h02AA_BBCC; em[1][1] = 32'hDDEE_1122;
        wr(wa(1, 9'h1FF), 32'h3);
        chk(tx_start == 0, "R9 no start", tx_start, 0);
        @(negedge clk);
        rd(wa(1, 9'h1FF), d, dn); chk(d == 0, "R9 bits clear", d, 0);
        chk(station == exp_station(32'h02AA_BBCC, 32'hDDEE_1122), "R9 station",
            station, exp_station(32'h02AA_BBCC, 32'hDDEE_1122));
        chk(np_station == 0, "R10 pong load ignored", np_station, 0);

        // R10 pong removed
        rd(wa(1, 9'd0), d, dn); chk(dn == 0, "R10 pong data zero", dn, 0);
        wr(wa(1, 9'h1FF), 32'h8000_0009);
        rd(wa(1, 9'h1FF), d, dn); chk(dn == 0, "R10 pong status zero", dn, 0);
        chk(np_start == 0 && np_active == 0, "R10 no pong start", {np_start, np_active}, 0);
        repeat (2 * SER) @(negedge clk);

        // random rounds: R1 R2 R5 R7 R10
        for (int it = 0; it < 12; it++) begin
            bit b, ie, sw;
            logic [15:0] len;
            b = 1'($urandom_range(0, 1));
            for (int j = 0; j < 4; j++) begin
                int idx;
                logic [31:0] v;
                idx = $urandom_range(0, NW - 1);
                v = $urandom;
                wr(wa(b, 9'(idx)), v);
                em[b][idx] = v;
                rd(wa(b, 9'(idx)), d, dn);
                chk(d == em[b][idx], b ? "R2 pong data" : "R1 ping data", d, em[b][idx]);
                if (b) chk(dn == 0, "R10 pong data ignored", dn, 0);
            end
            len = 16'($urandom);
            ie = 1'($urandom_range(0, 1));
            sw = 1'($urandom_range(0, 1));
            send(b, len, ie, sw);
            if (b) chk(np_active == 0 && np_irq == 0, "R10 no pong activity",
                       {np_active, np_irq}, 0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule